// File: doc/BRIEF.md
# SHA-256 Memory-Fetch Hash Engine

This block computes the SHA-256 digest of a fixed-length message that sits in a shared single-port word memory. It starts on a rising edge of its start input. It then fetches the message itself, one 32-bit word per cycle, beginning at a message base address. The padding and the 64-bit length field are generated in logic. With the default length the padded message forms exactly two 512-bit blocks, which are compressed one after the other.

When the second block is finished, the eight digest words are stored back to memory at consecutive addresses starting at a result base address. After that the block raises its completion flag and keeps it high until the next start edge. Both base addresses are captured when the start edge is accepted. The memory is clocked from the core clock and returns read data one cycle after the address is presented.

Top module: `sha256_mem_engine`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `done_o` and `mem_we_o` are 0. A reset applied partway through a hash aborts it, and no digest word is written afterwards.
- R2: A hash begins only on a 0-to-1 transition of `start_i`. Holding `start_i` high for many cycles, including past completion, produces exactly one hash: 8 writes and one rise of `done_o`.
- R3: The message is `MSG_WORDS` (default 20) 32-bit words, read from `msg_base_i + 0` upward. Read data is taken one cycle after the address is presented, and memory outside the message does not affect the result.
- R4: The padded input is two 512-bit blocks. Words 0..19 are the message, word 20 is 0x80000000, words 21..30 are 0, and word 31 is the bit length, 640.
- R5: The digest is standard SHA-256. Compression starts from the standard initial hash values, and the second block continues from the chaining value left by the first block.
- R6: Digest word Hi (H0 first) is written to `dig_base_i + i` for i = 0..7, in ascending order on consecutive cycles. Exactly 8 writes occur per hash.
- R7: `done_o` rises only in the cycle after the eighth write. It stays high until the next accepted start edge and falls in the cycle after that edge.
- R8: Both base addresses are sampled on the accepted start edge. Changing `msg_base_i` or `dig_base_i` during a hash has no effect on where data is read or written.
- R9: `mem_clk_o` is the core clock `clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request; a rising edge begins one hash |
| msg_base_i | input | 16 | Word address of message word 0 |
| dig_base_i | input | 16 | Word address for digest word H0 |
| done_o | output | 1 | High from completion until the next start edge |
| mem_clk_o | output | 1 | Memory clock, equal to clk_i |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid one cycle after the address |

## Verification
The bench builds the engine with its defaults: `MSG_WORDS` = 20 and a 16-bit address. With these values the second block holds four message words, the pad marker at word 20, ten zero words and the length 640. A single fault in padding position, length value, block chaining or fetch latency therefore changes every digest word. Base addresses are spread across a 4096-word model memory filled with address-dependent garbage, so a read outside the message or a misplaced write is visible in the result or in a sentinel location.

// File: rtl/sha256_eng_pkg.sv
`timescale 1ns/1ps
package sha256_eng_pkg;
  typedef logic [31:0] word_t;
  typedef logic [7:0][31:0] state_t; // [0]=a .. [7]=h

  localparam state_t IV = {32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
                           32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667};

  function automatic word_t rotr(word_t x, int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic word_t big_s0(word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_s1(word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t sml_s0(word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml_s1(word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t round_k(logic [5:0] i);
    case (i)
      6'd0:  return 32'h428a2f98; 6'd1:  return 32'h71374491; 6'd2:  return 32'hb5c0fbcf; 6'd3:  return 32'he9b5dba5;
      6'd4:  return 32'h3956c25b; 6'd5:  return 32'h59f111f1; 6'd6:  return 32'h923f82a4; 6'd7:  return 32'hab1c5ed5;
      6'd8:  return 32'hd807aa98; 6'd9:  return 32'h12835b01; 6'd10: return 32'h243185be; 6'd11: return 32'h550c7dc3;
      6'd12: return 32'h72be5d74; 6'd13: return 32'h80deb1fe; 6'd14: return 32'h9bdc06a7; 6'd15: return 32'hc19bf174;
      6'd16: return 32'he49b69c1; 6'd17: return 32'hefbe4786; 6'd18: return 32'h0fc19dc6; 6'd19: return 32'h240ca1cc;
      6'd20: return 32'h2de92c6f; 6'd21: return 32'h4a7484aa; 6'd22: return 32'h5cb0a9dc; 6'd23: return 32'h76f988da;
      6'd24: return 32'h983e5152; 6'd25: return 32'ha831c66d; 6'd26: return 32'hb00327c8; 6'd27: return 32'hbf597fc7;
      6'd28: return 32'hc6e00bf3; 6'd29: return 32'hd5a79147; 6'd30: return 32'h06ca6351; 6'd31: return 32'h14292967;
      6'd32: return 32'h27b70a85; 6'd33: return 32'h2e1b2138; 6'd34: return 32'h4d2c6dfc; 6'd35: return 32'h53380d13;
      6'd36: return 32'h650a7354; 6'd37: return 32'h766a0abb; 6'd38: return 32'h81c2c92e; 6'd39: return 32'h92722c85;
      6'd40: return 32'ha2bfe8a1; 6'd41: return 32'ha81a664b; 6'd42: return 32'hc24b8b70; 6'd43: return 32'hc76c51a3;
      6'd44: return 32'hd192e819; 6'd45: return 32'hd6990624; 6'd46: return 32'hf40e3585; 6'd47: return 32'h106aa070;
      6'd48: return 32'h19a4c116; 6'd49: return 32'h1e376c08; 6'd50: return 32'h2748774c; 6'd51: return 32'h34b0bcb5;
      6'd52: return 32'h391c0cb3; 6'd53: return 32'h4ed8aa4a; 6'd54: return 32'h5b9cca4f; 6'd55: return 32'h682e6ff3;
      6'd56: return 32'h748f82ee; 6'd57: return 32'h78a5636f; 6'd58: return 32'h84c87814; 6'd59: return 32'h8cc70208;
      6'd60: return 32'h90befffa; 6'd61: return 32'ha4506ceb; 6'd62: return 32'hbef9a3f7; default: return 32'hc67178f2;
    endcase
  endfunction
endpackage

// File: rtl/sha256_eng_round.sv
`timescale 1ns/1ps
module sha256_eng_round
  import sha256_eng_pkg::*;
(
  input  state_t st_i,
  input  word_t  k_i,
  input  word_t  w_i,
  output state_t st_o
);
  word_t t1, t2, ch, mj;

  always_comb begin
    ch = (st_i[4] & st_i[5]) ^ (~st_i[4] & st_i[6]);
    mj = (st_i[0] & st_i[1]) ^ (st_i[0] & st_i[2]) ^ (st_i[1] & st_i[2]);
    t1 = st_i[7] + big_s1(st_i[4]) + ch + k_i + w_i;
    t2 = big_s0(st_i[0]) + mj;
    st_o[0] = t1 + t2;
    st_o[1] = st_i[0];
    st_o[2] = st_i[1];
    st_o[3] = st_i[2];
    st_o[4] = st_i[3] + t1;
    st_o[5] = st_i[4];
    st_o[6] = st_i[5];
    st_o[7] = st_i[6];
  end
endmodule

// File: rtl/sha256_eng_sched.sv
`timescale 1ns/1ps
module sha256_eng_sched
  import sha256_eng_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,   // shift in word_i
  input  logic  shift_i,  // shift in expanded word
  input  word_t word_i,
  output word_t w_o
);
  localparam int WIN = 16;

  word_t win_q [WIN];
  word_t nxt;

  assign nxt = load_i ? word_i
                      : win_q[0] + sml_s0(win_q[1]) + win_q[9] + sml_s1(win_q[14]);
  assign w_o = win_q[0];

  for (genvar i = 0; i < WIN; i++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                win_q[i] <= '0;
      else if (load_i || shift_i) win_q[i] <= (i == WIN - 1) ? nxt : win_q[(i + 1) % WIN];
    end
  end

  // R3
  ctl_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_i, shift_i}));
endmodule

// File: rtl/sha256_mem_engine.sv
`timescale 1ns/1ps
module sha256_mem_engine
  import sha256_eng_pkg::*;
#(
  parameter int MSG_WORDS = 20,
  parameter int AW        = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] msg_base_i,
  input  logic [AW-1:0] dig_base_i,
  output logic          done_o,
  output logic          mem_clk_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i
);
  localparam int         BLK_WORDS = 16;
  localparam int         ROUNDS    = 64;
  localparam int         DIG_WORDS = 8;
  localparam logic [5:0] MSG_W6    = 6'(MSG_WORDS);
  localparam word_t      LEN_BITS  = 32'(MSG_WORDS * 32);
  localparam logic [6:0] LD_LAST   = 7'(BLK_WORDS);
  localparam logic [6:0] RND_LAST  = 7'(ROUNDS - 1);
  localparam logic [6:0] WR_LAST   = 7'(DIG_WORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_COMP, S_FOLD, S_WRITE, S_DONE} st_e;

  st_e           state_q;
  logic          blk_q, start_q;
  logic [6:0]    cnt_q;
  logic [AW-1:0] msg_base_q, dig_base_q;
  state_t        hv_q, wk_q, rnd_out, fold_sum;

  logic          start_edge, ld_shift;
  logic [4:0]    iss_idx, rx_idx, rx_off;
  word_t         ld_word, w_cur;

  assign mem_clk_o  = clk_i;
  assign start_edge = start_i && !start_q;

  // fetch index issued this cycle, and the one whose data arrives now
  assign iss_idx  = {blk_q, cnt_q[3:0]};
  assign rx_off   = 5'(cnt_q - 7'd1);
  assign rx_idx   = {blk_q, 4'b0} + {1'b0, rx_off[3:0]};
  assign ld_shift = (state_q == S_LOAD) && (cnt_q != 7'd0);

  always_comb begin
    if ({1'b0, rx_idx} < MSG_W6)      ld_word = mem_rdata_i;
    else if ({1'b0, rx_idx} == MSG_W6) ld_word = 32'h8000_0000;
    else if (rx_idx == 5'd31)          ld_word = LEN_BITS;
    else                               ld_word = '0;
  end

  sha256_eng_sched i_sched (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld_shift),
    .shift_i(state_q == S_COMP),
    .word_i (ld_word),
    .w_o    (w_cur)
  );

  sha256_eng_round i_round (
    .st_i(wk_q),
    .k_i (round_k(cnt_q[5:0])),
    .w_i (w_cur),
    .st_o(rnd_out)
  );

  always_comb
    for (int i = 0; i < 8; i++) fold_sum[i] = hv_q[i] + wk_q[i];

  always_comb begin
    mem_we_o    = (state_q == S_WRITE);
    mem_wdata_o = hv_q[cnt_q[2:0]];
    mem_addr_o  = mem_we_o ? dig_base_q + AW'(cnt_q[2:0]) : msg_base_q + AW'(iss_idx);
  end

  assign done_o = (state_q == S_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      blk_q      <= 1'b0;
      start_q    <= 1'b0;
      cnt_q      <= '0;
      msg_base_q <= '0;
      dig_base_q <= '0;
      hv_q       <= '0;
      wk_q       <= '0;
    end else begin
      start_q <= start_i;
      unique case (state_q)
        S_IDLE, S_DONE: if (start_edge) begin
          msg_base_q <= msg_base_i;
          dig_base_q <= dig_base_i;
          hv_q       <= IV;
          wk_q       <= IV;
          blk_q      <= 1'b0;
          cnt_q      <= '0;
          state_q    <= S_LOAD;
        end
        S_LOAD: begin
          cnt_q <= cnt_q + 7'd1;
          if (cnt_q == LD_LAST) begin
            cnt_q   <= '0;
            state_q <= S_COMP;
          end
        end
        S_COMP: begin
          wk_q  <= rnd_out;
          cnt_q <= cnt_q + 7'd1;
          if (cnt_q == RND_LAST) begin
            cnt_q   <= '0;
            state_q <= S_FOLD;
          end
        end
        S_FOLD: begin
          hv_q    <= fold_sum;
          wk_q    <= fold_sum;
          blk_q   <= 1'b1;
          state_q <= blk_q ? S_WRITE : S_LOAD;
        end
        S_WRITE: begin
          cnt_q <= cnt_q + 7'd1;
          if (cnt_q == WR_LAST) begin
            cnt_q   <= '0;
            state_q <= S_DONE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R7
  done_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mem_we_o) && ($past(mem_addr_o) == dig_base_q + AW'(DIG_WORDS - 1)));

  // R6
  wr_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == AW'($past(mem_addr_o) + AW'(1))));

  // R2
  held_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i && $past(start_i)) |=> done_o);

  // R8
  base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && state_q != S_IDLE && $past(state_q) != S_IDLE && $past(state_q) != S_DONE)
      |-> ($stable(dig_base_q) && $stable(msg_base_q)));
endmodule

// File: tb/test_sha256_mem_engine.sv
`timescale 1ns/1ps
module test_sha256_mem_engine;
  localparam int MSG_WORDS = 20;
  localparam int AW        = 16;
  localparam int MEM_SZ    = 4096;

  typedef struct packed {
    logic [31:0] seed;
    logic [31:0] mix;
    logic [15:0] mb;
    logic [15:0] db;
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VECS [NVEC] = '{
    '{seed: 32'h0123_4567, mix: 32'h0000_0000, mb: 16'd0,    db: 16'd1000},
    '{seed: 32'h0000_0000, mix: 32'h0000_0000, mb: 16'd100,  db: 16'd50},
    '{seed: 32'hffff_ffff, mix: 32'h0000_0000, mb: 16'd2000, db: 16'd4088},
    '{seed: 32'hdead_beef, mix: 32'h9e37_79b9, mb: 16'd3000, db: 16'd2990}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] msg_base = '0, dig_base = '0;
  logic done, mem_clk, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem [MEM_SZ];
  logic [31:0] kc [64];
  logic [31:0] ivc [8];
  logic [31:0] msgw [MSG_WORDS];
  logic [31:0] exp_h [8];

  int checks = 0, errors = 0, wr_cnt = 0;

  always #10 clk = ~clk;

  sha256_mem_engine #(.MSG_WORDS(MSG_WORDS), .AW(AW)) i_sha256_mem_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .msg_base_i(msg_base), .dig_base_i(dig_base), .done_o(done),
    .mem_clk_o(mem_clk), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always @(posedge mem_clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    else        mem_rdata <= mem[mem_addr[11:0]];
  end

  always @(posedge clk) if (rst_n && mem_we) wr_cnt = wr_cnt + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] gen_word(input vec_t v, input int m);
    logic [31:0] r;
    r = (m == 0) ? v.seed : ((v.seed << m) | (v.seed >> (32 - m)));
    return r ^ (v.mix * 32'(m));
  endfunction

  task automatic init_consts();
    int p = 2, found = 0;
    while (found < 64) begin
      bit prime = 1'b1;
      for (int d = 2; d * d <= p; d++) if (p % d == 0) prime = 1'b0;
      if (prime) begin
        real r, fr;
        longint lv;
        r  = $pow(real'(p), 1.0 / 3.0);
        fr = r - $floor(r);
        lv = longint'($floor(fr * 4294967296.0));
        kc[found] = lv[31:0];
        if (found < 8) begin
          r  = $sqrt(real'(p));
          fr = r - $floor(r);
          lv = longint'($floor(fr * 4294967296.0));
          ivc[found] = lv[31:0];
        end
        found++;
      end
      p++;
    end
  endtask

  // reference: padding per R4, compression per R5
  task automatic ref_digest();
    logic [31:0] blk [32];
    logic [31:0] w [64];
    logic [31:0] hs [8];
    logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
    for (int i = 0; i < 32; i++)
      blk[i] = (i < MSG_WORDS) ? msgw[i] : (i == MSG_WORDS) ? 32'h8000_0000 :
               (i == 31) ? 32'(MSG_WORDS * 32) : 32'h0;
    for (int i = 0; i < 8; i++) hs[i] = ivc[i];
    for (int bk = 0; bk < 2; bk++) begin
      for (int t = 0; t < 64; t++)
        if (t < 16) w[t] = blk[bk * 16 + t];
        else w[t] = w[t-16] + w[t-7]
                  + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3))
                  + (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10));
      {a, b, c, d, e, f, g, h} = {hs[0], hs[1], hs[2], hs[3], hs[4], hs[5], hs[6], hs[7]};
      for (int t = 0; t < 64; t++) begin
        t1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + kc[t] + w[t];
        t2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
        {a, b, c, d, e, f, g, h} = {t1 + t2, a, b, c, d + t1, e, f, g};
      end
      hs[0] += a; hs[1] += b; hs[2] += c; hs[3] += d;
      hs[4] += e; hs[5] += f; hs[6] += g; hs[7] += h;
    end
    for (int i = 0; i < 8; i++) exp_h[i] = hs[i];
  endtask

  task automatic prep(input vec_t v);
    for (int i = 0; i < MEM_SZ; i++) mem[i] = 32'ha5a5_0000 ^ 32'(i * 7919);
    for (int m = 0; m < MSG_WORDS; m++) begin
      msgw[m] = gen_word(v, m);
      mem[v.mb + 16'(m)] = msgw[m];
    end
    ref_digest();
  endtask

  // hold: cycles start stays high; move: change bases mid-run
  task automatic run_hash(input vec_t v, input int hold, input bit move);
    bit seen = 1'b0, drop_ok = 1'b1;
    int done_cyc = 0;
    prep(v);
    @(negedge clk);
    wr_cnt   = 0;
    msg_base = v.mb;
    dig_base = v.db;
    start    = 1'b1;
    for (int cyc = 1; cyc < 3000; cyc++) begin
      @(negedge clk);
      if (cyc == 1) check("R7 done falls after start", {31'b0, done}, 32'd0);
      if (cyc >= hold) start = 1'b0;
      if (move && cyc == 4) begin
        msg_base = 16'd512;
        dig_base = 16'd3500;
      end
      if (seen && !done) drop_ok = 1'b0;
      if (done && !seen) begin
        seen = 1'b1;
        done_cyc = cyc;
        check("R7 done only after 8th write", 32'(wr_cnt), 32'd8);
      end
      if (seen && cyc >= hold && cyc >= done_cyc + 4) break;
    end
    check("R7 done raised and held", {30'b0, seen, drop_ok}, 32'd3);
    check("R6 exactly 8 writes", 32'(wr_cnt), 32'd8);
    // R4 R5 R6: digest words in order at the sampled base
    for (int i = 0; i < 8; i++)
      check($sformatf("R5 digest H%0d", i), mem[v.db + 16'(i)], exp_h[i]);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    init_consts();
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 done in reset", {31'b0, done}, 32'd0);
    check("R1 we in reset", {31'b0, mem_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", {31'b0, done}, 32'd0);
    // R9: memory clock follows core clock in both phases
    check("R9 mem_clk low phase", {31'b0, mem_clk}, {31'b0, clk});
    @(posedge clk); #1;
    check("R9 mem_clk high phase", {31'b0, mem_clk}, {31'b0, clk});

    // R3 R4 R5: vector table
    for (int v = 0; v < NVEC; v++) run_hash(VECS[v], 2, 1'b0);

    // R2: start held across the whole hash and beyond
    run_hash(VECS[3], 400, 1'b0);
    check("R2 single hash under held start", 32'(wr_cnt), 32'd8);

    // R8: bases change mid-run; alternate result area untouched
    run_hash(VECS[0], 1, 1'b1);
    check("R8 alt base untouched", mem[3500], 32'ha5a5_0000 ^ 32'(3500 * 7919));

    // R1: reset partway through a hash
    prep(VECS[1]);
    @(negedge clk);
    wr_cnt   = 0;
    msg_base = VECS[1].mb;
    dig_base = VECS[1].db;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 done in mid-run reset", {31'b0, done}, 32'd0);
    check("R1 we in mid-run reset", {31'b0, mem_we}, 32'd0);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    check("R1 no writes after abort", 32'(wr_cnt), 32'd0);
    check("R1 done stays low after abort", {31'b0, done}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule